// File: doc/BRIEF.md
# Warp Run-Ahead Pre-Execution Controller

This controller sits between the decode stage and the issue stage of one warp in a GPU pipeline. In normal operation it forwards each decoded instruction to issue unchanged. When the pipeline reports that the warp has stalled on a long-latency operation, such as an off-chip load, the controller enters a run-ahead mode and keeps consuming decoded instructions. It follows the dependence chain of the pending value with one poison bit per architectural register, and it drops every instruction on that chain. Independent instructions that write a register are issued with their destination moved to a spare physical register. Independent global loads become L1 prefetch requests.

When the stalling operation completes, the controller returns to normal mode. It emits a one-cycle redirect to the instruction after the stalling one. While that code is fetched again, any instruction whose PC matches a live entry of the reuse table is issued as a reuse. The issue stage then copies its result from the spare register and does not execute it again. Spare registers and reuse entries are one pool: reuse slot `k` owns physical register `NUM_ARCH + k`.

Both data streams use valid/ready. An instruction is consumed in a cycle where `in_valid && in_ready`. `in_ready` follows `iss_ready` when the instruction goes to issue, follows `pf_ready` when it becomes a prefetch, is 1 when the instruction is dropped, and is 0 in the cycle a run-ahead episode ends. Outputs are combinational from the input instruction, and nothing changes state until the instruction is consumed. The stall, completion and redirect pins are plain pulses.

Top module: `warp_preexec_ctrl`

## Requirements
- R1: After reset the controller is in normal mode (`preexec_active`=0), `redir_valid` and `pf_valid` are 0, `iss_valid` is 0 while `in_valid` is 0, and the reuse table holds no entries.
- R2: In normal mode an instruction with no reuse hit is presented on issue with `iss_valid`=`in_valid`, `iss_dst_phys`, `iss_src0_phys` and `iss_src1_phys` equal to the architectural indices zero-extended, `iss_reuse`=0, and `in_ready`=`iss_ready`.
- R3: A `stall_valid` pulse in normal mode sets `preexec_active` from the next cycle, poisons `stall_dst`, and empties the reuse table.
- R4: In run-ahead mode an instruction that reads no poisoned source, is not a global load and writes a register (`in_dst_en`=1) is issued with `iss_dst_phys` = `NUM_ARCH` + lowest free slot. Later readers of that architectural register get that spare as their source physical index.
- R5: In run-ahead mode an instruction that reads an enabled poisoned source is consumed with `in_ready`=1, no issue and no prefetch, and it poisons its destination. An instruction issued per R4 clears the poison of its destination.
- R6: In run-ahead mode an independent global load (`in_is_gload`=1) raises `pf_valid` with `pf_pc`=`in_pc` and `pf_base_phys` = physical index of source 0. It never issues, `in_ready`=`pf_ready`, and it poisons its destination.
- R7: When all `NUM_SPARE` spares are held, a further independent register-writing instruction is consumed without issue, poisons its destination, and run-ahead mode continues.
- R8: `ld_done` in run-ahead mode holds `in_ready` at 0 for that cycle. From the next cycle the mode is normal, poison and rename state are clear, and `redir_valid` is high for exactly one cycle with `redir_pc` = stalling PC + 1.
- R9: In normal mode an instruction whose PC matches a live reuse entry issues with `iss_reuse`=1 and `iss_dst_phys` = that entry's spare. The entry is freed when the instruction is consumed, so the same PC does not hit again.
- R10: A run-ahead instruction that writes a register without being renamed (dropped or prefetched) invalidates every reuse entry that read that register as a source.
- R11: In run-ahead mode an independent instruction that writes no register (`in_dst_en`=0) is consumed without issue or prefetch.
- R12: Entries left from an earlier episode are discarded when a new episode starts and produce no hit afterwards.
- R13: `stall_valid` during run-ahead mode and `ld_done` during normal mode are ignored: the mode and the redirect target do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction valid |
| in_ready | output | 1 | Decoded instruction consumed this cycle when high with in_valid |
| in_pc | input | PC_W | Instruction PC |
| in_dst | input | log2(NUM_ARCH) | Destination architectural register |
| in_dst_en | input | 1 | Instruction writes a register |
| in_src0 | input | log2(NUM_ARCH) | Source 0 register |
| in_src0_en | input | 1 | Source 0 used |
| in_src1 | input | log2(NUM_ARCH) | Source 1 register |
| in_src1_en | input | 1 | Source 1 used |
| in_is_gload | input | 1 | Instruction is a global memory load |
| stall_valid | input | 1 | Warp stalled on a long-latency operation |
| stall_pc | input | PC_W | PC of the stalling instruction |
| stall_dst | input | log2(NUM_ARCH) | Register awaiting the long-latency result |
| ld_done | input | 1 | Long-latency operation completed |
| iss_valid | output | 1 | Issue request valid |
| iss_ready | input | 1 | Issue stage accepts |
| iss_pc | output | PC_W | Issued PC |
| iss_dst | output | log2(NUM_ARCH) | Architectural destination |
| iss_dst_en | output | 1 | Issued instruction writes a register |
| iss_dst_phys | output | log2(NUM_ARCH+NUM_SPARE) | Physical destination, or result location on reuse |
| iss_src0_phys | output | log2(NUM_ARCH+NUM_SPARE) | Physical source 0 |
| iss_src1_phys | output | log2(NUM_ARCH+NUM_SPARE) | Physical source 1 |
| iss_reuse | output | 1 | Result already computed in iss_dst_phys |
| pf_valid | output | 1 | L1 prefetch request valid |
| pf_ready | input | 1 | Prefetch accepted |
| pf_pc | output | PC_W | PC of the converted load |
| pf_base_phys | output | log2(NUM_ARCH+NUM_SPARE) | Physical register holding the address base |
| preexec_active | output | 1 | Run-ahead mode |
| redir_valid | output | 1 | One-cycle fetch redirect |
| redir_pc | output | PC_W | Redirect target |

## Verification
The embedded assertions check on every cycle that prefetches appear only in run-ahead mode and never together with an issue, that run-ahead issues always target a spare, that reuse hits appear only in normal mode, that allocation only happens with a free slot, and that the redirect is a single pulse with the target held through an episode. Only the directed scenarios can show the dependence chain through several instructions, the order in which spares are handed out, invalidation by a later writer, freeing of entries on reuse, discarding of stale entries by a new episode, and the correct resume PC.

// File: rtl/wpx_pkg.sv
package wpx_pkg;

  // What happens to the instruction at the input this cycle
  typedef enum logic [2:0] {
    DISP_PASS,      // normal mode: forward to issue
    DISP_RENAME,    // run-ahead: issue into a spare register
    DISP_PREFETCH,  // run-ahead: global load becomes a prefetch
    DISP_DROP,      // run-ahead: consumed, nothing issued
    DISP_HOLD       // episode ending: not consumed
  } disp_e;

endpackage

// File: rtl/wpx_mode.sv
module wpx_mode #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_valid,
  input  logic [PC_W-1:0] stall_pc,
  input  logic            ld_done,
  output logic            active,
  output logic            enter,
  output logic            leave,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc
);

  logic [PC_W-1:0] resume_q;

  assign enter    = stall_valid && !active;
  assign leave    = ld_done && active;
  assign redir_pc = resume_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      resume_q    <= '0;
      redir_valid <= 1'b0;
    end else begin
      redir_valid <= leave;
      if (enter) begin
        active   <= 1'b1;
        resume_q <= stall_pc + PC_W'(1);
      end else if (leave) begin
        active <= 1'b0;
      end
    end
  end

  AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid); // R8
  AST_LEAVE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> (!active && redir_valid)); // R8
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(resume_q)); // R13

endmodule

// File: rtl/wpx_dep_track.sv
module wpx_dep_track #(
  parameter int NUM_ARCH  = 32,
  parameter int NUM_SPARE = 8,
  localparam int AW  = $clog2(NUM_ARCH),
  localparam int SW  = $clog2(NUM_SPARE),
  localparam int PHW = $clog2(NUM_ARCH + NUM_SPARE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enter_en,
  input  logic [AW-1:0]  enter_reg,
  input  logic           leave_en,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_reg,
  input  logic           wr_renamed,
  input  logic [SW-1:0]  wr_slot,
  input  logic [AW-1:0]  rd0_reg,
  input  logic [AW-1:0]  rd1_reg,
  input  logic [AW-1:0]  dst_reg,
  output logic           rd0_poisoned,
  output logic           rd1_poisoned,
  output logic [PHW-1:0] rd0_phys,
  output logic [PHW-1:0] rd1_phys,
  output logic [PHW-1:0] dst_arch_phys
);

  logic [NUM_ARCH-1:0] poison_q;
  logic [NUM_ARCH-1:0] mapped_q;
  logic [SW-1:0]       slot_q [NUM_ARCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poison_q <= '0;
      mapped_q <= '0;
    end else if (leave_en) begin
      poison_q <= '0;
      mapped_q <= '0;
    end else if (enter_en) begin
      poison_q <= NUM_ARCH'(1) << enter_reg;
      mapped_q <= '0;
    end else if (wr_en) begin
      poison_q[wr_reg] <= !wr_renamed;
      mapped_q[wr_reg] <= wr_renamed;
    end
  end

  // Slot payload is qualified by mapped_q, so it carries no reset
  always_ff @(posedge clk) begin
    if (wr_en && wr_renamed) slot_q[wr_reg] <= wr_slot;
  end

  function automatic logic [PHW-1:0] to_phys(input logic [AW-1:0] r,
                                             input logic m,
                                             input logic [SW-1:0] s);
    return m ? (PHW'(NUM_ARCH) + PHW'(s)) : PHW'(r);
  endfunction

  assign rd0_poisoned  = poison_q[rd0_reg];
  assign rd1_poisoned  = poison_q[rd1_reg];
  assign rd0_phys      = to_phys(rd0_reg, mapped_q[rd0_reg], slot_q[rd0_reg]);
  assign rd1_phys      = to_phys(rd1_reg, mapped_q[rd1_reg], slot_q[rd1_reg]);
  assign dst_arch_phys = PHW'(dst_reg);

  AST_ENTER_LEAVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_en && leave_en)); // R3
  AST_ENTRY_POISONS: assert property (@(posedge clk) disable iff (!rst_n)
    enter_en |=> poison_q[$past(enter_reg)]); // R3
  AST_LEAVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    leave_en |=> (poison_q == '0 && mapped_q == '0)); // R8

endmodule

// File: rtl/wpx_reuse_tab.sv
module wpx_reuse_tab #(
  parameter int NUM_ARCH  = 32,
  parameter int NUM_SPARE = 8,
  parameter int PC_W      = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int SW = $clog2(NUM_SPARE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic [SW-1:0]   lk_slot,
  output logic            free_any,
  output logic [SW-1:0]   free_slot,
  input  logic            alloc_en,
  input  logic [PC_W-1:0] alloc_pc,
  input  logic [AW-1:0]   alloc_s0,
  input  logic            alloc_s0_en,
  input  logic [AW-1:0]   alloc_s1,
  input  logic            alloc_s1_en,
  input  logic            rel_en,
  input  logic [SW-1:0]   rel_slot,
  input  logic            inv_en,
  input  logic [AW-1:0]   inv_reg
);

  logic [NUM_SPARE-1:0] live_q;
  logic [PC_W-1:0]      pc_q  [NUM_SPARE];
  logic [AW-1:0]        s0_q  [NUM_SPARE];
  logic [AW-1:0]        s1_q  [NUM_SPARE];
  logic [NUM_SPARE-1:0] s0e_q;
  logic [NUM_SPARE-1:0] s1e_q;
  logic [NUM_SPARE-1:0] reads_inv;

  // Lowest-index search for a PC match and for a free slot
  always_comb begin
    lk_hit    = 1'b0;
    lk_slot   = '0;
    free_any  = 1'b0;
    free_slot = '0;
    for (int i = NUM_SPARE - 1; i >= 0; i--) begin
      if (live_q[i] && pc_q[i] == lk_pc) begin
        lk_hit  = 1'b1;
        lk_slot = SW'(i);
      end
      if (!live_q[i]) begin
        free_any  = 1'b1;
        free_slot = SW'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_SPARE; g++) begin : g_cmp
    assign reads_inv[g] = (s0e_q[g] && s0_q[g] == inv_reg) ||
                          (s1e_q[g] && s1_q[g] == inv_reg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (flush) begin
      live_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SPARE; i++) begin
        if (alloc_en && free_slot == SW'(i))
          live_q[i] <= 1'b1;
        else if (rel_en && rel_slot == SW'(i))
          live_q[i] <= 1'b0;
        else if (inv_en && reads_inv[i])
          live_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SPARE; i++) begin
      if (alloc_en && free_slot == SW'(i)) begin
        pc_q[i]  <= alloc_pc;
        s0_q[i]  <= alloc_s0;
        s1_q[i]  <= alloc_s1;
        s0e_q[i] <= alloc_s0_en;
        s1e_q[i] <= alloc_s1_en;
      end
    end
  end

  AST_ALLOC_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> free_any); // R7
  AST_RELEASE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> live_q[rel_slot]); // R9
  AST_ALLOC_RELEASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_en && rel_en)); // R9

endmodule

// File: rtl/warp_preexec_ctrl.sv
module warp_preexec_ctrl #(
  parameter int NUM_ARCH  = 32,
  parameter int NUM_SPARE = 8,
  parameter int PC_W      = 16,
  localparam int AW  = $clog2(NUM_ARCH),
  localparam int SW  = $clog2(NUM_SPARE),
  localparam int PHW = $clog2(NUM_ARCH + NUM_SPARE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PC_W-1:0] in_pc,
  input  logic [AW-1:0]   in_dst,
  input  logic            in_dst_en,
  input  logic [AW-1:0]   in_src0,
  input  logic            in_src0_en,
  input  logic [AW-1:0]   in_src1,
  input  logic            in_src1_en,
  input  logic            in_is_gload,
  input  logic            stall_valid,
  input  logic [PC_W-1:0] stall_pc,
  input  logic [AW-1:0]   stall_dst,
  input  logic            ld_done,
  output logic            iss_valid,
  input  logic            iss_ready,
  output logic [PC_W-1:0] iss_pc,
  output logic [AW-1:0]   iss_dst,
  output logic            iss_dst_en,
  output logic [PHW-1:0]  iss_dst_phys,
  output logic [PHW-1:0]  iss_src0_phys,
  output logic [PHW-1:0]  iss_src1_phys,
  output logic            iss_reuse,
  output logic            pf_valid,
  input  logic            pf_ready,
  output logic [PC_W-1:0] pf_pc,
  output logic [PHW-1:0]  pf_base_phys,
  output logic            preexec_active,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc
);
  import wpx_pkg::*;

  logic           enter, leave;
  logic           p0_pois, p1_pois, dep;
  logic [PHW-1:0] s0_phys, s1_phys, dst_arch_phys;
  logic           lk_hit, free_any;
  logic [SW-1:0]  lk_slot, free_slot;
  disp_e          disp;
  logic           fire;
  logic           wr_en, alloc_en, rel_en, inv_en;

  wpx_mode #(.PC_W(PC_W)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_valid (stall_valid),
    .stall_pc    (stall_pc),
    .ld_done     (ld_done),
    .active      (preexec_active),
    .enter       (enter),
    .leave       (leave),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc)
  );

  wpx_dep_track #(.NUM_ARCH(NUM_ARCH), .NUM_SPARE(NUM_SPARE)) u_dep (
    .clk           (clk),
    .rst_n         (rst_n),
    .enter_en      (enter),
    .enter_reg     (stall_dst),
    .leave_en      (leave),
    .wr_en         (wr_en),
    .wr_reg        (in_dst),
    .wr_renamed    (disp == DISP_RENAME),
    .wr_slot       (free_slot),
    .rd0_reg       (in_src0),
    .rd1_reg       (in_src1),
    .dst_reg       (in_dst),
    .rd0_poisoned  (p0_pois),
    .rd1_poisoned  (p1_pois),
    .rd0_phys      (s0_phys),
    .rd1_phys      (s1_phys),
    .dst_arch_phys (dst_arch_phys)
  );

  wpx_reuse_tab #(.NUM_ARCH(NUM_ARCH), .NUM_SPARE(NUM_SPARE), .PC_W(PC_W)) u_tab (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (enter),
    .lk_pc       (in_pc),
    .lk_hit      (lk_hit),
    .lk_slot     (lk_slot),
    .free_any    (free_any),
    .free_slot   (free_slot),
    .alloc_en    (alloc_en),
    .alloc_pc    (in_pc),
    .alloc_s0    (in_src0),
    .alloc_s0_en (in_src0_en),
    .alloc_s1    (in_src1),
    .alloc_s1_en (in_src1_en),
    .rel_en      (rel_en),
    .rel_slot    (lk_slot),
    .inv_en      (inv_en),
    .inv_reg     (in_dst)
  );

  assign dep = (in_src0_en && p0_pois) || (in_src1_en && p1_pois);

  // Disposition of the instruction at the input
  always_comb begin
    if (!preexec_active)                 disp = DISP_PASS;
    else if (ld_done)                    disp = DISP_HOLD;
    else if (dep)                        disp = DISP_DROP;
    else if (in_is_gload)                disp = DISP_PREFETCH;
    else if (!in_dst_en || !free_any)    disp = DISP_DROP;
    else                                 disp = DISP_RENAME;
  end

  always_comb begin
    unique case (disp)
      DISP_PASS, DISP_RENAME: in_ready = iss_ready;
      DISP_PREFETCH:          in_ready = pf_ready;
      DISP_DROP:              in_ready = 1'b1;
      default:                in_ready = 1'b0;
    endcase
  end

  assign fire = in_valid && in_ready;

  assign iss_valid  = in_valid && (disp == DISP_PASS || disp == DISP_RENAME);
  assign pf_valid   = in_valid && (disp == DISP_PREFETCH);
  assign iss_reuse  = (disp == DISP_PASS) && lk_hit;
  assign iss_pc     = in_pc;
  assign iss_dst    = in_dst;
  assign iss_dst_en = in_dst_en;
  assign pf_pc      = in_pc;
  assign pf_base_phys  = s0_phys;
  assign iss_src0_phys = s0_phys;
  assign iss_src1_phys = s1_phys;

  always_comb begin
    if (disp == DISP_RENAME)
      iss_dst_phys = PHW'(NUM_ARCH) + PHW'(free_slot);
    else if (iss_reuse)
      iss_dst_phys = PHW'(NUM_ARCH) + PHW'(lk_slot);
    else
      iss_dst_phys = dst_arch_phys;
  end

  // State updates only on a consumed instruction
  assign wr_en    = fire && preexec_active && in_dst_en;
  assign alloc_en = fire && (disp == DISP_RENAME);
  assign rel_en   = fire && iss_reuse;
  assign inv_en   = fire && preexec_active && in_dst_en && (disp != DISP_RENAME);

  AST_PF_RUNAHEAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> preexec_active); // R6
  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid && pf_valid)); // R6
  AST_RUNAHEAD_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && preexec_active) |-> (iss_dst_phys >= PHW'(NUM_ARCH))); // R4
  AST_REUSE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    iss_reuse |-> !preexec_active); // R9
  AST_HOLD_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (preexec_active && ld_done) |-> !in_ready); // R8

endmodule

// File: tb/test_warp_preexec_ctrl.sv
module test_warp_preexec_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_dst_en = 0, in_src0_en = 0, in_src1_en = 0, in_is_gload = 0;
  logic [15:0] in_pc = '0;
  logic [4:0]  in_dst = '0, in_src0 = '0, in_src1 = '0;
  logic stall_valid = 0, ld_done = 0, iss_ready = 1, pf_ready = 1;
  logic [15:0] stall_pc = '0;
  logic [4:0]  stall_dst = '0;
  logic in_ready, iss_valid, iss_dst_en, iss_reuse, pf_valid, preexec_active, redir_valid;
  logic [15:0] iss_pc, pf_pc, redir_pc;
  logic [4:0]  iss_dst;
  logic [5:0]  iss_dst_phys, iss_src0_phys, iss_src1_phys, pf_base_phys;

  int tests = 0, fails = 0;
  int c_rdy, c_iss, c_pf, c_dphys, c_s0phys, c_reuse, c_pfpc, c_pfbase;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_preexec_ctrl i_warp_preexec_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
    .in_dst(in_dst), .in_dst_en(in_dst_en), .in_src0(in_src0), .in_src0_en(in_src0_en),
    .in_src1(in_src1), .in_src1_en(in_src1_en), .in_is_gload(in_is_gload),
    .stall_valid(stall_valid), .stall_pc(stall_pc), .stall_dst(stall_dst), .ld_done(ld_done),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_pc(iss_pc), .iss_dst(iss_dst),
    .iss_dst_en(iss_dst_en), .iss_dst_phys(iss_dst_phys), .iss_src0_phys(iss_src0_phys),
    .iss_src1_phys(iss_src1_phys), .iss_reuse(iss_reuse), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_pc(pf_pc), .pf_base_phys(pf_base_phys),
    .preexec_active(preexec_active), .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Present one instruction from the falling edge, sample outputs, commit at the rising edge
  task automatic send(input int pc, input int dst, input bit den, input int s0,
                      input bit s0e, input bit gl);
    @(negedge clk);
    in_valid = 1; in_pc = 16'(pc); in_dst = 5'(dst); in_dst_en = den;
    in_src0 = 5'(s0); in_src0_en = s0e; in_src1 = '0; in_src1_en = 0; in_is_gload = gl;
    #1;
    c_rdy = in_ready; c_iss = iss_valid; c_pf = pf_valid; c_dphys = iss_dst_phys;
    c_s0phys = iss_src0_phys; c_reuse = iss_reuse; c_pfpc = pf_pc; c_pfbase = pf_base_phys;
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic stall(input int dst, input int pc);
    @(negedge clk);
    stall_valid = 1; stall_dst = 5'(dst); stall_pc = 16'(pc);
    @(posedge clk); #1;
    stall_valid = 0;
  endtask

  task automatic finish_load();
    @(negedge clk);
    ld_done = 1;
    @(posedge clk); #1;
    ld_done = 0;
  endtask

  task automatic t_reset();
    chk("R1", "mode", preexec_active, 0);
    chk("R1", "redir_valid", redir_valid, 0);
    chk("R1", "pf_valid", pf_valid, 0);
    chk("R1", "iss_valid idle", iss_valid, 0);
    finish_load();
    chk("R13", "done in normal keeps mode", preexec_active, 0);
    chk("R13", "done in normal no redirect", redir_valid, 0);
  endtask

  task automatic t_normal();
    send(10, 3, 1, 1, 1, 0);
    chk("R2", "iss_valid", c_iss, 1);
    chk("R2", "dst phys", c_dphys, 3);
    chk("R2", "src0 phys", c_s0phys, 1);
    chk("R1", "no reuse on empty table", c_reuse, 0);
    iss_ready = 0;
    send(11, 4, 1, 2, 1, 0);
    chk("R2", "backpressure in_ready", c_rdy, 0);
    chk("R2", "valid under backpressure", c_iss, 1);
    iss_ready = 1;
  endtask

  task automatic t_episode();
    stall(5, 20);
    chk("R3", "mode entered", preexec_active, 1);
    send(21, 6, 1, 5, 1, 0);
    chk("R5", "dependent not issued", c_iss, 0);
    chk("R5", "dependent consumed", c_rdy, 1);
    chk("R5", "dependent no prefetch", c_pf, 0);
    send(22, 7, 1, 1, 1, 0);
    chk("R4", "renamed issue", c_iss, 1);
    chk("R4", "first spare", c_dphys, 32);
    send(23, 8, 1, 7, 1, 0);
    chk("R4", "source from spare", c_s0phys, 32);
    chk("R4", "second spare", c_dphys, 33);
    send(24, 9, 1, 6, 1, 0);
    chk("R5", "chain dependent skipped", c_iss, 0);
    pf_ready = 0;
    send(25, 10, 1, 2, 1, 1);
    chk("R6", "prefetch backpressure", c_rdy, 0);
    pf_ready = 1;
    send(25, 10, 1, 2, 1, 1);
    chk("R6", "prefetch valid", c_pf, 1);
    chk("R6", "prefetch pc", c_pfpc, 25);
    chk("R6", "prefetch base", c_pfbase, 2);
    chk("R6", "load not issued", c_iss, 0);
    send(26, 11, 1, 10, 1, 0);
    chk("R6", "load dst poisoned", c_iss, 0);
    send(27, 0, 0, 1, 1, 0);
    chk("R11", "no-dst skipped", c_iss, 0);
    chk("R11", "no-dst consumed", c_rdy, 1);
    send(28, 6, 1, 3, 1, 0);
    chk("R5", "independent overwrite issued", c_dphys, 34);
    send(29, 12, 1, 6, 1, 0);
    chk("R5", "poison cleared by rename", c_iss, 1);
    chk("R5", "reads new spare", c_s0phys, 34);
    send(30, 1, 1, 5, 1, 0);
    chk("R10", "dependent writer skipped", c_iss, 0);
    @(negedge clk);
    ld_done = 1; in_valid = 1; in_pc = 16'd31; in_dst_en = 1; in_src0_en = 0;
    #1;
    chk("R8", "hold during done", in_ready, 0);
    chk("R8", "no issue during done", iss_valid, 0);
    @(posedge clk); #1;
    ld_done = 0; in_valid = 0;
    chk("R8", "back to normal", preexec_active, 0);
    chk("R8", "redirect pulse", redir_valid, 1);
    chk("R8", "redirect pc", redir_pc, 21);
    @(posedge clk); #1;
    chk("R8", "redirect one cycle", redir_valid, 0);
    send(21, 6, 1, 5, 1, 0);
    chk("R8", "replay issues normally", c_dphys, 6);
    chk("R8", "replay no reuse", c_reuse, 0);
    send(22, 7, 1, 1, 1, 0);
    chk("R10", "invalidated entry no hit", c_reuse, 0);
    send(23, 8, 1, 7, 1, 0);
    chk("R9", "reuse hit", c_reuse, 1);
    chk("R9", "reuse phys", c_dphys, 33);
    send(23, 8, 1, 7, 1, 0);
    chk("R9", "entry freed after use", c_reuse, 0);
    send(24, 9, 1, 6, 1, 0);
    chk("R8", "poison cleared on exit", c_iss, 1);
    chk("R8", "rename cleared on exit", c_s0phys, 6);
    send(28, 6, 1, 3, 1, 0);
    chk("R9", "second reuse phys", c_dphys, 34);
  endtask

  task automatic t_full();
    stall(2, 40);
    stall(9, 99);
    chk("R13", "stall in run-ahead keeps mode", preexec_active, 1);
    for (int k = 0; k < 8; k++) begin
      send(41 + k, 13 + k, 1, 1, 1, 0);
      chk("R4", "spare order", c_dphys, 32 + k);
    end
    send(49, 21, 1, 1, 1, 0);
    chk("R7", "full skip no issue", c_iss, 0);
    chk("R7", "full skip consumed", c_rdy, 1);
    chk("R7", "mode stays", preexec_active, 1);
    send(50, 22, 1, 21, 1, 0);
    chk("R7", "skipped dst poisoned", c_iss, 0);
    finish_load();
    chk("R13", "redirect target unchanged", redir_pc, 41);
    send(29, 12, 1, 6, 1, 0);
    chk("R12", "stale entry discarded", c_reuse, 0);
    chk("R12", "stale pc arch dst", c_dphys, 12);
    send(41, 13, 1, 1, 1, 0);
    chk("R9", "hit first slot", c_dphys, 32);
    send(48, 20, 1, 1, 1, 0);
    chk("R9", "hit last slot", c_dphys, 39);
    send(49, 21, 1, 1, 1, 0);
    chk("R7", "skipped pc no hit", c_reuse, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_normal();
    t_episode();
    t_full();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule